// File: doc/BRIEF.md
# LIN Break Detector with Receive Masking

This block watches a serial receive line for a LIN break: a low level that lasts at least a programmed number of count-source periods. The duration is timed by a down counter. The counter steps only on a single-cycle count enable `cnt_tick`, which is generated in the system clock domain. A low pulse that ends before the counter expires reloads the counter. The block then waits for the next low level. After a break is found, the counter is reloaded and stays idle until the line has gone high again.

The block also sits between the line and a downstream UART receiver. Software raises `lin_go`. After a short handshake that spans both the system clock and the count source, the block masks the UART input to idle-high. Until then the line passes straight through. When a break is found, the block either releases the mask on its own or keeps it until software drops `lin_go`, depending on `hold_mask`. Three sticky status flags (collision, break, sync-measured) are cleared by writing 1 to their own clear inputs. The collision and sync-measured flags are set by external detectors.

Top module: `lin_break_det`

## Requirements
- R1: While `rx_masked` is 0, `uart_rxd` equals `rxd_in` delayed by exactly two system clock edges (a two-flop synchronizer). After reset, the synchronized line is 1.
- R2: While `rx_masked` is 1, `uart_rxd` is 1, whatever the line does.
- R3: `rx_masked` rises on the first clock edge at which `cnt_tick` is 1 and `lin_go` was sampled 1 on the two previous edges. With `cnt_tick` high every cycle, it reads 0 after two edges and 1 after three edges from the edge that first samples `lin_go`=1.
- R4: `tmr_running` becomes 1 on the first edge at which `cnt_tick` is 1 while `tmr_go` is 1. It returns to 0 on the edge after `tmr_go` is sampled 0.
- R5: While `tmr_running` and `rx_masked` are both 1, a break is detected when the synchronized line has been low on `brk_len` consecutive tick edges. A `brk_len` of 0 behaves as 1.
- R6: A low pulse shorter than `brk_len` ticks reloads the counter when the line goes high. Ticks from separate low pulses never add up to a break.
- R7: After a break, the counter is reloaded. No further break is detected until the line has returned high and gone low again.
- R8: `brk_seen` becomes 1 one system clock edge after the internal break detection.
- R9: With `hold_mask`=0, `rx_masked` returns to 0 on the edge of a break detection, and the line passes to the UART until `lin_go` is lowered and raised again. With `hold_mask`=1, `rx_masked` stays 1 after a break until `lin_go` is sampled 0, and then falls on that edge.
- R10: `coll_flag`, `brk_seen` and `sync_flag` are sticky. Each is cleared only by a 1 on its own clear input (`clr_coll`, `clr_brk`, `clr_sync`). A 0 on a clear input has no effect. A set in the same cycle as a clear wins.
- R11: After reset, all status flags are 0 and `uart_rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-source enable, one system cycle wide |
| rxd_in | input | 1 | Raw serial receive line |
| uart_rxd | output | 1 | Receive line toward the UART, held high while masked |
| lin_go | input | 1 | Start bit: request masking and break search |
| hold_mask | input | 1 | 1 keeps the mask after a break; 0 releases it |
| tmr_go | input | 1 | Counter start bit |
| brk_len | input | CNT_W | Break threshold in count-source ticks |
| clr_coll | input | 1 | Write-1 clear of collision flag |
| clr_brk | input | 1 | Write-1 clear of break flag |
| clr_sync | input | 1 | Write-1 clear of sync-measured flag |
| coll_set | input | 1 | Set pulse from an external collision detector |
| sync_set | input | 1 | Set pulse from an external sync-field timer |
| tmr_running | output | 1 | Counter running status |
| rx_masked | output | 1 | UART input masked status |
| brk_seen | output | 1 | Break detected flag |
| coll_flag | output | 1 | Bus collision flag |
| sync_flag | output | 1 | Sync field measured flag |

## Verification
The break threshold is swept over every low-pulse length around each threshold, first with a tick every cycle and then with a tick every third cycle. The bench predicts a break exactly when the number of low ticks reaches the threshold, which separates an off-by-one counter from a correct one. Two short pulses separated by a single high cycle show whether the counter reloads or accumulates. A long continuous low, with the flag cleared mid-pulse, shows whether detection re-arms without a rising edge. The handshake window and the two mask-hold modes are checked by looking at whether a low level reaches `uart_rxd`.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
   localparam int NUM_FLG  = 3;
   localparam int FLG_COLL = 0;
   localparam int FLG_BRK  = 1;
   localparam int FLG_SYNC = 2;
   typedef logic [NUM_FLG-1:0] flg_vec_t;
endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lin_len_timer.sv
module lin_len_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             tmr_go,
   input  logic             active,
   input  logic             rx_low,
   input  logic [CNT_W-1:0] len,
   output logic             running,
   output logic             hit
);
   logic [CNT_W-1:0] cnt;
   logic             wait_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         hit     <= 1'b0;
         cnt     <= '0;
         wait_hi <= 1'b0;
      end else begin
         hit     <= 1'b0;
         running <= tmr_go & (running | tick);
         if (!running || !active || !rx_low) begin
            cnt     <= len;
            wait_hi <= 1'b0;
         end else if (tick && !wait_hi) begin
            if (cnt <= CNT_W'(1)) begin
               hit     <= 1'b1;
               cnt     <= len;
               wait_hi <= 1'b1;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

   assert_run_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(tick) && $past(tmr_go));
   assert_hit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(tick) && $past(rx_low) && $past(active));
   assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> cnt == $past(len));
   assert_no_rehit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit && rx_low |=> !hit);
endmodule

// File: rtl/lin_mask_ctl.sv
module lin_mask_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic lin_go,
   input  logic hold_mask,
   input  logic hit,
   output logic masked
);
   logic req1, req2, released;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req1     <= 1'b0;
         req2     <= 1'b0;
         released <= 1'b0;
         masked   <= 1'b0;
      end else begin
         req1 <= lin_go;
         req2 <= req1 & lin_go;
         if (!lin_go) begin
            masked   <= 1'b0;
            released <= 1'b0;
         end else if (hit && !hold_mask && masked) begin
            masked   <= 1'b0;
            released <= 1'b1;
         end else if (req2 && tick && !released) begin
            masked <= 1'b1;
         end
      end
   end

   assert_go_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lin_go |=> !masked);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      masked && hold_mask && lin_go |=> masked);
   assert_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(masked) |-> $past(tick) && $past(lin_go) && $past(lin_go, 2));
endmodule

// File: rtl/lin_flags.sv
module lin_flags
   import lin_brk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  flg_vec_t set_v,
   input  flg_vec_t clr_v,
   output flg_vec_t flg
);
   generate
      for (genvar i = 0; i < NUM_FLG; i++) begin : g_flg
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) flg[i] <= 1'b0;
            else        flg[i] <= set_v[i] | (flg[i] & ~clr_v[i]);

         assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> flg[i]);
         assert_w0_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
            flg[i] && !clr_v[i] |=> flg[i]);
         assert_w1_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            clr_v[i] && !set_v[i] |=> !flg[i]);
      end
   endgenerate
endmodule

// File: rtl/lin_break_det.sv
module lin_break_det
   import lin_brk_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_tick,
   input  logic             rxd_in,
   output logic             uart_rxd,
   input  logic             lin_go,
   input  logic             hold_mask,
   input  logic             tmr_go,
   input  logic [CNT_W-1:0] brk_len,
   input  logic             clr_coll,
   input  logic             clr_brk,
   input  logic             clr_sync,
   input  logic             coll_set,
   input  logic             sync_set,
   output logic             tmr_running,
   output logic             rx_masked,
   output logic             brk_seen,
   output logic             coll_flag,
   output logic             sync_flag
);
   generate
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_w
         $error("lin_break_det: CNT_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("lin_break_det: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic     rx_s, hit;
   flg_vec_t set_v, clr_v, flg;

   lin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd_in), .q(rx_s));

   lin_len_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .tmr_go(tmr_go),
      .active(rx_masked), .rx_low(~rx_s), .len(brk_len),
      .running(tmr_running), .hit(hit));

   lin_mask_ctl u_mask (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .lin_go(lin_go),
      .hold_mask(hold_mask), .hit(hit), .masked(rx_masked));

   always_comb begin
      set_v           = '0;
      clr_v           = '0;
      set_v[FLG_COLL] = coll_set;
      set_v[FLG_BRK]  = hit;
      set_v[FLG_SYNC] = sync_set;
      clr_v[FLG_COLL] = clr_coll;
      clr_v[FLG_BRK]  = clr_brk;
      clr_v[FLG_SYNC] = clr_sync;
   end

   lin_flags u_flg (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .flg(flg));

   assign coll_flag = flg[FLG_COLL];
   assign brk_seen  = flg[FLG_BRK];
   assign sync_flag = flg[FLG_SYNC];
   assign uart_rxd  = rx_masked ? 1'b1 : rx_s;

   assert_mask_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_masked |-> uart_rxd);
   assert_flag_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> brk_seen);
   assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !hold_mask && lin_go |=> !rx_masked);
endmodule

// File: tb/sim_lin_break_det.sv
module sim_lin_break_det;
   localparam int CLK_P = 10;
   localparam int CW    = 8;

   logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b0, rxd_in = 1'b1;
   logic lin_go = 1'b0, hold_mask = 1'b1, tmr_go = 1'b0;
   logic [CW-1:0] brk_len = '0;
   logic clr_coll = 0, clr_brk = 0, clr_sync = 0, coll_set = 0, sync_set = 0;
   logic uart_rxd, tmr_running, rx_masked, brk_seen, coll_flag, sync_flag;
   int total = 0, bad = 0;
   int tick_per = 1, tick_ph = 0;

   lin_break_det #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .rxd_in(rxd_in),
      .uart_rxd(uart_rxd), .lin_go(lin_go), .hold_mask(hold_mask),
      .tmr_go(tmr_go), .brk_len(brk_len), .clr_coll(clr_coll),
      .clr_brk(clr_brk), .clr_sync(clr_sync), .coll_set(coll_set),
      .sync_set(sync_set), .tmr_running(tmr_running), .rx_masked(rx_masked),
      .brk_seen(brk_seen), .coll_flag(coll_flag), .sync_flag(sync_flag));

   always #(CLK_P/2) clk = ~clk;

   always @(negedge clk) begin
      tick_ph  = (tick_ph + 1 >= tick_per) ? 0 : tick_ph + 1;
      cnt_tick <= (tick_ph == 0);
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one break trial with the line low for lo cycles
   task automatic trial(input int n, input int lo, input int exp_brk);
      int leak = 0;
      @(negedge clk); brk_len = CW'(n); clr_brk = 1;
      @(negedge clk); clr_brk = 0;
      cyc(2);
      rxd_in = 0;
      for (int i = 0; i < lo; i++) begin
         @(negedge clk);
         if (uart_rxd !== 1'b1) leak++;
      end
      rxd_in = 1;
      cyc(6);
      chk("R2 masked line stays high", leak, 0);
      chk($sformatf("R5 break N=%0d low=%0d per=%0d", n, lo, tick_per),
          int'(brk_seen), exp_brk);
   endtask

   initial begin
      #(CLK_P * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cyc(3);
      // R11 reset state
      chk("R11 brk_seen", int'(brk_seen), 0);
      chk("R11 flags", int'({coll_flag, sync_flag, rx_masked, tmr_running}), 0);
      chk("R11 uart_rxd", int'(uart_rxd), 1);
      rst_n = 1;
      cyc(2);

      // R4 counter start waits for a tick
      tick_per = 4;
      cyc(4);
      tmr_go = 1;
      begin
         int seen = 0;
         for (int i = 0; i < 6; i++) begin
            #1;
            if (cnt_tick) seen = 1;
            @(negedge clk);
            chk("R4 running after tick", int'(tmr_running), seen);
         end
      end
      tmr_go = 0;
      cyc(1);
      chk("R4 stop", int'(tmr_running), 0);
      tmr_go = 1;
      tick_per = 1;
      cyc(6);
      chk("R4 restart", int'(tmr_running), 1);

      // R1 / R3 handshake window, line passes straight through
      brk_len = CW'(50);
      hold_mask = 1;
      lin_go = 1; rxd_in = 0;
      cyc(2);
      chk("R3 masked not yet", int'(rx_masked), 0);
      chk("R1 low passes before mask", int'(uart_rxd), 0);
      cyc(1);
      chk("R3 masked after third edge", int'(rx_masked), 1);
      chk("R2 masked output", int'(uart_rxd), 1);
      rxd_in = 1;
      cyc(4);

      // R5 sweep, tick every cycle
      for (int n = 0; n < 6; n++)
         for (int lo = 1; lo < 8; lo++)
            trial(n, lo, (lo >= ((n == 0) ? 1 : n)) ? 1 : 0);

      // R5 sweep, tick every third cycle
      tick_per = 3;
      for (int n = 1; n < 5; n++)
         for (int k = 1; k < 6; k++)
            trial(n, 3 * k, (k >= n) ? 1 : 0);
      tick_per = 1;
      cyc(3);

      // R6 two short pulses with one high cycle do not add up
      @(negedge clk); brk_len = CW'(4); clr_brk = 1;
      @(negedge clk); clr_brk = 0;
      rxd_in = 0; cyc(3); rxd_in = 1; cyc(1); rxd_in = 0; cyc(3); rxd_in = 1;
      cyc(6);
      chk("R6 no accumulation", int'(brk_seen), 0);

      // R7 long low gives one break only
      @(negedge clk); brk_len = CW'(2); clr_brk = 1;
      @(negedge clk); clr_brk = 0;
      rxd_in = 0; cyc(6);
      chk("R7 first break", int'(brk_seen), 1);
      clr_brk = 1; cyc(1); clr_brk = 0;
      cyc(6);
      chk("R7 no rearm while low", int'(brk_seen), 0);
      rxd_in = 1; cyc(4);
      rxd_in = 0; cyc(6);
      chk("R7 rearm after high", int'(brk_seen), 1);
      rxd_in = 1; cyc(4);
      chk("R9 hold keeps mask", int'(rx_masked), 1);
      lin_go = 0; cyc(1);
      chk("R9 go low drops mask", int'(rx_masked), 0);

      // R9 automatic release
      hold_mask = 0;
      clr_brk = 1; cyc(1); clr_brk = 0;
      lin_go = 1; cyc(5);
      chk("R9 remasked", int'(rx_masked), 1);
      rxd_in = 0; cyc(5);
      chk("R8 flag set", int'(brk_seen), 1);
      chk("R9 released", int'(rx_masked), 0);
      chk("R1 line reaches uart", int'(uart_rxd), 0);
      rxd_in = 1; cyc(3);
      chk("R1 high reaches uart", int'(uart_rxd), 1);
      cyc(4);
      chk("R9 stays released", int'(rx_masked), 0);
      lin_go = 0; hold_mask = 1; cyc(2);

      // R10 write-1-to-clear
      coll_set = 1; sync_set = 1; cyc(1); coll_set = 0; sync_set = 0; cyc(1);
      chk("R10 coll set", int'(coll_flag), 1);
      chk("R10 sync set", int'(sync_flag), 1);
      cyc(3);
      chk("R10 write 0 keeps coll", int'(coll_flag), 1);
      clr_coll = 1; cyc(1); clr_coll = 0; cyc(1);
      chk("R10 coll cleared", int'(coll_flag), 0);
      chk("R10 sync untouched", int'(sync_flag), 1);
      chk("R10 brk untouched", int'(brk_seen), 1);
      sync_set = 1; clr_sync = 1; cyc(1); sync_set = 0; clr_sync = 0; cyc(1);
      chk("R10 set beats clear", int'(sync_flag), 1);
      clr_sync = 1; clr_brk = 1; cyc(1); clr_sync = 0; clr_brk = 0; cyc(1);
      chk("R10 sync cleared", int'(sync_flag), 0);
      chk("R10 brk cleared", int'(brk_seen), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule